// File: doc/BRIEF.md
# Dual-clock countdown event timer

This block is a single countdown channel that software drives through a small memory-mapped register window. Software holds a 64-bit reload value in two 32-bit words and sets run, mode and interrupt-unmask flags in a control word. The countdown itself runs on a separate timer clock. When the count reaches zero, the block sets a sticky pending flag in the bus domain. When that flag is unmasked, it drives a level interrupt.

There are two counting styles. In auto-reload mode the counter restarts from the reload value after every zero, so events come out at a fixed period. In single-shot mode the counter halts at zero and stays there until software drops the run flag and raises it again. The usual reprogramming sequence is: stop, write the reload words, then start with the chosen mode. This sequence works even when the three writes arrive on back-to-back bus cycles.

Configuration moves into the timer domain as one bundled snapshot under a request/acknowledge toggle handshake. Terminal events return to the bus domain as a toggle that passes through a synchronizer. A parameter picks one of two placements of the control word in the address map.

The bus side is plain register access and has no back-pressure: every write is taken in the cycle it is presented, and read data depends combinationally on the address.

Top module: `evt_timer`

## Requirements
- R1: After reset, every mapped register reads 0 and `irq` is low.
- R2: Byte offsets are: reload low word 0x00, reload high word 0x04, pending flag 0x18. The control word sits at 0x10 when VARIANT=1 and at 0x1C when VARIANT=2. Reload words read back as written. The control word reads back bits 2:0 as written and 0 above them. Control bit 0 = run, bit 1 = single-shot (0 selects auto-reload), bit 2 = interrupt unmask.
- R3: Any offset not listed in R2 reads 0 and ignores writes, including the control offset of the other variant.
- R4: In auto-reload mode with reload value N, terminal events occur every N+1 timer-clock cycles.
- R5: In single-shot mode exactly one terminal event occurs. Writing the control word again with run still 1 does not restart the counter. Clearing run and then setting it again does restart it.
- R6: A 0-to-1 transition of run loads the counter from the reload words. A stop / reload-write / start sequence on consecutive bus cycles re-arms the counter with the new value, even when the counter was already running.
- R7: A reload-word write while the counter runs does not alter the count in progress. It takes effect at the next reload.
- R8: A terminal event sets the pending flag (bit 0 of 0x18). Writing 1 to that bit clears it, and writing 0 leaves it set.
- R9: `irq` is high exactly when the pending flag is 1 and control bit 2 is 1. A masked event still sets the pending flag.
- R10: The full 64-bit reload value is counted: a nonzero high word extends the count beyond 2^32 cycles, and a high word of 0 gives a 32-bit count.
- R11: Writing 0 to the control word stops counting, and no further terminal events follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-access clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tmr_clk | input | 1 | Counting clock |
| tmr_rst_n | input | 1 | Asynchronous active-low reset, timer domain |
| irq | output | 1 | Level interrupt: pending flag AND unmask |

## Verification
The bench builds the block with VARIANT=2 and SYNC_STAGES=2. With VARIANT=2 the bench can write the variant-1 control offset and confirm that the write is ignored. The timer clock has the same frequency as the bus clock but a fixed phase offset, so the latency of every crossing is constant. This lets the bench measure periods between successive interrupts to the exact cycle, and shows the N+1 period and the one-period delay of a reload-word update. The default 64-bit reload width puts the nonzero-high-word case within reach: a count that never finishes inside the run.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int WORD_W = 32;
  localparam int LOAD_W = 2 * WORD_W;
  localparam int OFS_W  = 5;

  localparam logic [OFS_W-1:0] OFS_RELOAD_LO = 5'h00;
  localparam logic [OFS_W-1:0] OFS_RELOAD_HI = 5'h04;
  localparam logic [OFS_W-1:0] OFS_CTRL_A    = 5'h10;
  localparam logic [OFS_W-1:0] OFS_PENDING   = 5'h18;
  localparam logic [OFS_W-1:0] OFS_CTRL_B    = 5'h1C;

  // control word layout: bit 0 run, bit 1 single-shot, bit 2 unmask
  typedef struct packed {
    logic unmask;
    logic single;
    logic run;
  } ctrl_t;

  typedef struct packed {
    logic              rearm;
    ctrl_t             ctrl;
    logic [LOAD_W-1:0] reload;
  } cfg_t;

  function automatic logic [OFS_W-1:0] ctrl_offset(input int variant);
    return (variant == 2) ? OFS_CTRL_B : OFS_CTRL_A;
  endfunction
endpackage

// File: rtl/evtmr_sync.sv
module evtmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  if (STAGES > 1) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
    end
  end else begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= d;
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/evtmr_regs.sv
module evtmr_regs
  import evtmr_pkg::*;
#(
  parameter int VARIANT = 1,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              evt_tog_s,
  output ctrl_t             ctrl_o,
  output logic [LOAD_W-1:0] reload_o,
  output logic              cfg_write,
  output logic              run_rise,
  output logic              irq
);
  localparam logic [OFS_W-1:0] CTRL_OFS = ctrl_offset(VARIANT);

  logic [WORD_W-1:0] reload_lo, reload_hi;
  ctrl_t             ctrl_q;
  logic              pending, evt_prev, evt_edge;
  logic              hit_lo, hit_hi, hit_ctrl, hit_pend;

  assign hit_lo   = (addr == ADDR_W'(OFS_RELOAD_LO));
  assign hit_hi   = (addr == ADDR_W'(OFS_RELOAD_HI));
  assign hit_ctrl = (addr == ADDR_W'(CTRL_OFS));
  assign hit_pend = (addr == ADDR_W'(OFS_PENDING));

  assign evt_edge  = evt_tog_s ^ evt_prev;
  assign cfg_write = wr && (hit_lo || hit_hi || hit_ctrl);
  assign run_rise  = wr && hit_ctrl && wdata[0] && !ctrl_q.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_lo <= '0;
      reload_hi <= '0;
      ctrl_q    <= '0;
      pending   <= 1'b0;
      evt_prev  <= 1'b0;
    end else begin
      evt_prev <= evt_tog_s;
      if (wr && hit_lo)   reload_lo <= wdata;
      if (wr && hit_hi)   reload_hi <= wdata;
      if (wr && hit_ctrl) ctrl_q    <= ctrl_t'(wdata[2:0]);
      // a fresh event wins over a simultaneous clear
      if (evt_edge)                           pending <= 1'b1;
      else if (wr && hit_pend && wdata[0])    pending <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_lo)        rdata = reload_lo;
    else if (hit_hi)   rdata = reload_hi;
    else if (hit_ctrl) rdata = WORD_W'(ctrl_q);
    else if (hit_pend) rdata = WORD_W'(pending);
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = {reload_hi, reload_lo};
  assign irq      = pending && ctrl_q.unmask;

  // R8: an arriving event leaves the flag set
  a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_edge |=> pending);
  // R8: write-one clears when no event competes
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_pend && wdata[0] && !evt_edge) |=> !pending);
  // R3: unmapped writes leave configuration untouched
  a_r3_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !(hit_lo || hit_hi || hit_ctrl || hit_pend))
      |=> ($stable(reload_lo) && $stable(reload_hi) && $stable(ctrl_q)));
endmodule

// File: rtl/evtmr_cfg_xfer.sv
module evtmr_cfg_xfer
  import evtmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  ctrl_t             live_ctrl,
  input  logic [LOAD_W-1:0] live_reload,
  input  logic              cfg_write,
  input  logic              run_rise,
  input  logic              tmr_clk,
  input  logic              tmr_rst_n,
  output cfg_t              tmr_cfg,
  output logic              tmr_upd
);
  // bus side
  cfg_t snap;
  logic dirty, rearm_pend, busy, req_tog, ack_s;
  // timer side
  logic req_s, req_seen;

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      snap       <= '0;
      dirty      <= 1'b0;
      rearm_pend <= 1'b0;
      busy       <= 1'b0;
      req_tog    <= 1'b0;
    end else begin
      if (!busy && dirty) begin
        snap       <= cfg_t'{rearm: rearm_pend, ctrl: live_ctrl, reload: live_reload};
        req_tog    <= ~req_tog;
        busy       <= 1'b1;
        dirty      <= cfg_write;
        rearm_pend <= run_rise;
      end else begin
        if (cfg_write) dirty      <= 1'b1;
        if (run_rise)  rearm_pend <= 1'b1;
        if (busy && (ack_s == req_tog)) busy <= 1'b0;
      end
    end
  end

  evtmr_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(tmr_clk), .rst_n(tmr_rst_n), .d(req_tog), .q(req_s));

  always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
    if (!tmr_rst_n) begin
      req_seen <= 1'b0;
      tmr_cfg  <= '0;
      tmr_upd  <= 1'b0;
    end else begin
      tmr_upd <= (req_s != req_seen);
      if (req_s != req_seen) begin
        req_seen <= req_s;
        tmr_cfg  <= snap;
      end
    end
  end

  evtmr_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(req_seen), .q(ack_s));

  // R6: the snapshot stays still while the timer side may sample it
  a_r6_snap_held: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    busy |=> $stable(snap));
endmodule

// File: rtl/evtmr_core.sv
module evtmr_core
  import evtmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg,
  input  logic upd,
  output logic evt_tog
);
  logic [LOAD_W-1:0] cnt;
  logic              running, run_prev, start;

  assign start = upd && cfg.ctrl.run && (!run_prev || cfg.rearm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      running  <= 1'b0;
      run_prev <= 1'b0;
      evt_tog  <= 1'b0;
    end else begin
      if (upd) run_prev <= cfg.ctrl.run;
      if (start) begin
        cnt     <= cfg.reload;
        running <= 1'b1;
      end else if (!cfg.ctrl.run) begin
        running <= 1'b0;
      end else if (running) begin
        if (cnt == '0) begin
          evt_tog <= ~evt_tog;
          if (cfg.ctrl.single) running <= 1'b0;
          else                 cnt     <= cfg.reload;
        end else begin
          cnt <= cnt - LOAD_W'(1);
        end
      end
    end
  end

  // R4: counting down one per cycle
  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt != '0 && !upd && cfg.ctrl.run) |=> (cnt == $past(cnt) - LOAD_W'(1)));
  // R4: auto-reload on terminal count
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt == '0 && !upd && cfg.ctrl.run && !cfg.ctrl.single)
      |=> (running && cnt == $past(cfg.reload)));
  // R5: single-shot halts at terminal count
  a_r5_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt == '0 && !upd && cfg.ctrl.run && cfg.ctrl.single) |=> !running);
  // R5: a halted counter emits nothing without a new configuration
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !upd) |=> (!running && $stable(evt_tog)));
  // R11: a configuration with run cleared stops the counter
  a_r11_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !cfg.ctrl.run) |=> !running);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evtmr_pkg::*;
#(
  parameter int VARIANT     = 1,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              tmr_clk,
  input  logic              tmr_rst_n,
  output logic              irq
);
  ctrl_t             live_ctrl;
  logic [LOAD_W-1:0] live_reload;
  logic              cfg_write, run_rise;
  cfg_t              tmr_cfg;
  logic              tmr_upd, evt_tog, evt_tog_s;

  evtmr_regs #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) u_regs (
    .clk(bus_clk), .rst_n(bus_rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .evt_tog_s(evt_tog_s),
    .ctrl_o(live_ctrl), .reload_o(live_reload), .cfg_write(cfg_write),
    .run_rise(run_rise), .irq(irq));

  evtmr_cfg_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .live_ctrl(live_ctrl),
    .live_reload(live_reload), .cfg_write(cfg_write), .run_rise(run_rise),
    .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n), .tmr_cfg(tmr_cfg),
    .tmr_upd(tmr_upd));

  evtmr_core u_core (
    .clk(tmr_clk), .rst_n(tmr_rst_n), .cfg(tmr_cfg), .upd(tmr_upd),
    .evt_tog(evt_tog));

  evtmr_sync #(.STAGES(SYNC_STAGES + 1)) u_evt_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(evt_tog), .q(evt_tog_s));
endmodule

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
  localparam int VARIANT = 2;
  localparam logic [4:0] A_LO = 5'h00, A_HI = 5'h04, A_PEND = 5'h18;
  localparam logic [4:0] A_CTRL = 5'h1C, A_OTHER_CTRL = 5'h10;

  logic        bus_clk = 1'b0, tmr_clk = 1'b0;
  logic        bus_rst_n = 1'b0, tmr_rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 bus_clk = ~bus_clk;
  initial begin
    #1;
    forever #2.5 tmr_clk = ~tmr_clk;
  end
  always @(posedge bus_clk) cyc <= cyc + 1;

  evt_timer #(.VARIANT(VARIANT), .ADDR_W(5), .SYNC_STAGES(2)) dut_i (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n), .irq(irq));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr32(input logic [4:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge bus_clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd32(input logic [4:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic wait_irq(input int lim, output bit got, output int t);
    got = 1'b0; t = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge bus_clk);
      if (irq) begin got = 1'b1; t = cyc; return; end
    end
  endtask

  task automatic clear_pending;
    wr32(A_PEND, 32'h1);
  endtask

  task automatic quiesce;
    wr32(A_CTRL, 32'h0);
    idle(40);
    clear_pending();
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd32(A_LO, v);   chk(v == 0, "R1 reload low", v, 0);
    rd32(A_HI, v);   chk(v == 0, "R1 reload high", v, 0);
    rd32(A_CTRL, v); chk(v == 0, "R1 control", v, 0);
    rd32(A_PEND, v); chk(v == 0, "R1 pending", v, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr32(A_LO, 32'h1234_5678); rd32(A_LO, v);
    chk(v == 32'h1234_5678, "R2 reload low readback", v, 32'h1234_5678);
    wr32(A_HI, 32'hCAFE_0001); rd32(A_HI, v);
    chk(v == 32'hCAFE_0001, "R2 reload high readback", v, 32'hCAFE_0001);
    wr32(A_CTRL, 32'hFFFF_FFF6); rd32(A_CTRL, v);
    chk(v == 32'h6, "R2 control readback", v, 6);
    wr32(A_CTRL, 32'h0);
    wr32(A_HI, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr32(A_LO, 32'd3);
    wr32(A_OTHER_CTRL, 32'h7);
    rd32(A_OTHER_CTRL, v); chk(v == 0, "R3 other-variant control reads 0", v, 0);
    rd32(A_CTRL, v);       chk(v == 0, "R3 control untouched", v, 0);
    wr32(5'h08, 32'hFFFF_FFFF);
    rd32(5'h08, v);        chk(v == 0, "R3 unmapped reads 0", v, 0);
    rd32(A_LO, v);         chk(v == 3, "R3 reload untouched", v, 3);
    idle(60);
    rd32(A_PEND, v);       chk(v == 0, "R3 no timer start", v, 0);
  endtask

  task automatic t_periodic;
    bit g0, g1, g2, g3, g4;
    int t0, t1, t2, t3, t4;
    logic [31:0] v;
    wr32(A_LO, 32'd19); wr32(A_HI, 32'd0); wr32(A_CTRL, 32'h5);
    wait_irq(200, g0, t0); clear_pending();
    wait_irq(200, g1, t1); clear_pending();
    wait_irq(200, g2, t2); clear_pending();
    chk(g0 && g1 && g2, "R4 periodic events seen", {g0, g1, g2}, 7);
    chk(t1 - t0 == 20, "R4 period N+1", t1 - t0, 20);
    chk(t2 - t1 == 20, "R4 period repeat", t2 - t1, 20);
    wr32(A_LO, 32'd9);
    wait_irq(200, g3, t3); clear_pending();
    wait_irq(200, g4, t4); clear_pending();
    chk(g3 && t3 - t2 == 20, "R7 running period unchanged", t3 - t2, 20);
    chk(g4 && t4 - t3 == 10, "R7 new reload at next reload", t4 - t3, 10);
    wr32(A_CTRL, 32'h0);
    idle(40); clear_pending();
    idle(150);
    rd32(A_PEND, v); chk(v == 0, "R11 no events after stop", v, 0);
  endtask

  task automatic t_single;
    bit g; int t; logic [31:0] v;
    wr32(A_LO, 32'd19); wr32(A_CTRL, 32'h5);
    wait_irq(200, g, t); clear_pending();
    chk(g, "R6 periodic before re-arm", g, 1);
    wr32(A_CTRL, 32'h0); wr32(A_LO, 32'd2); wr32(A_CTRL, 32'h7);
    wait_irq(200, g, t); clear_pending();
    chk(g, "R6 back-to-back re-arm fires", g, 1);
    idle(150);
    rd32(A_PEND, v); chk(v == 0, "R5 single-shot fires once", v, 0);
    wr32(A_CTRL, 32'h7);
    idle(150);
    rd32(A_PEND, v); chk(v == 0, "R5 rewrite with run held does not restart", v, 0);
    wr32(A_CTRL, 32'h0); wr32(A_CTRL, 32'h7);
    wait_irq(200, g, t); clear_pending();
    chk(g, "R5 stop then start restarts", g, 1);
    quiesce();
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr32(A_LO, 32'd3); wr32(A_CTRL, 32'h3);
    idle(100);
    chk(irq == 1'b0, "R9 masked irq stays low", irq, 0);
    rd32(A_PEND, v); chk(v == 1, "R9 masked event sets pending", v, 1);
    wr32(A_PEND, 32'h0);
    rd32(A_PEND, v); chk(v == 1, "R8 writing 0 keeps pending", v, 1);
    wr32(A_CTRL, 32'h7); idle(1);
    chk(irq == 1'b1, "R9 unmask raises irq", irq, 1);
    wr32(A_PEND, 32'h1);
    rd32(A_PEND, v); chk(v == 0, "R8 write 1 clears pending", v, 0);
    chk(irq == 1'b0, "R8 irq drops after clear", irq, 0);
    quiesce();
  endtask

  task automatic t_wide;
    bit g; int t; logic [31:0] v;
    wr32(A_HI, 32'd1); wr32(A_LO, 32'd0); wr32(A_CTRL, 32'h7);
    idle(300);
    rd32(A_PEND, v); chk(v == 0, "R10 high word extends count", v, 0);
    wr32(A_CTRL, 32'h0); wr32(A_HI, 32'd0); wr32(A_CTRL, 32'h7);
    wait_irq(100, g, t);
    chk(g, "R10 high word 0 gives short count", g, 1);
    quiesce();
  endtask

  initial begin
    idle(10);
    bus_rst_n = 1'b1; tmr_rst_n = 1'b1;
    idle(2);
    t_reset();
    t_regmap();
    t_unmapped();
    t_periodic();
    t_single();
    t_mask();
    t_wide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule